// File: doc/BRIEF.md
# Glitch-Safe Two-Level Clock Source Select Controller

This controller owns an 8-bit clock control register whose fields steer a two-stage clock selector. A secondary selector picks between a safe bus-derived clock and an auxiliary PLL clock. A primary selector picks one of three sources: the secondary selector's output, a high-frequency PLL, or that PLL divided by two. The clock cells themselves sit outside the block and are driven from the register outputs.

A requester asks for a change by holding `req_valid` high, with `req_tgt` naming the selector and `req_code` giving the select code. The controller then updates the register in the right order, one read-modify-write step at a time. After the write it waits a fixed settle time, counted in reference-clock cycles, and then pulses `done`. A secondary change is wrapped in a gating override. The override bit is set before the select field moves and is cleared only after the switch has settled. An illegal primary code produces a one-cycle `err` pulse and leaves the register untouched.

The state machine has these states:
- INIT: clears the divider field after reset.
- IDLE: waits for a request.
- PRI_WR, then PRI_SETTLE: a primary change.
- SEC_GATE_OFF, SEC_WR, SEC_SETTLE, then SEC_GATE_ON: a secondary change.
- DONE: pulses `done`.
- REJECT: pulses `err`.

The transitions are:
- INIT goes to IDLE.
- From IDLE, a valid request goes to PRI_WR, SEC_GATE_OFF or REJECT.
- Each SETTLE state leaves when the timer expires.
- DONE and REJECT both return to IDLE.

Top module: `clksel_ctrl`

## Requirements
- R1: During reset `ctrl` equals CTRL_INIT (default 8'hE5). In the single INIT cycle after reset, bits [7:6] are cleared, which selects divide-by-two for the divided PLL path. All other bits keep their reset value, so the default becomes 8'h25. Bits [7:6] stay 0 from then on.
- R2: A request with `req_tgt`=0 and a code of 0, 1 or 2 writes that code into bits [1:0] and leaves bits [7:2] unchanged. Code 0 selects the secondary output, 1 the PLL, and 2 the PLL divided by two. `busy` is high for SETTLE_CYC+2 cycles, and the last of these cycles carries `done`.
- R3: A request with `req_tgt`=0 and code 3 gives a single-cycle `err`, with `busy` high for that one cycle only. No `done` follows, and `ctrl` does not change.
- R4: A request with `req_tgt`=1 and any code 0 to 3 writes that code into bits [3:2] and leaves the other fields unchanged. Code 0 is the safe bus clock. `busy` is high for SETTLE_CYC+4 cycles, ending with `done`.
- R5: Bit 4, the gating override, is 1 in the cycle before and in the cycle after every change of bits [3:2]. It is 0 again when `done` is high.
- R6: On a primary change, `done` is seen exactly SETTLE_CYC cycles after the new value of bits [1:0] first appears. SETTLE_CYC = REF_MHZ*SETTLE_NS/1000, which is 200 by default.
- R7: While `busy` is high, `req_valid`, `req_tgt` and `req_code` are ignored. The request in progress completes with the values captured when it was accepted.
- R8: `pri_sel` always equals bits [1:0] of `ctrl`, and `sec_sel` always equals bits [3:2].
- R9: `done` and `err` are single-cycle pulses that are never high together, and `busy` is high while either of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request held high until `done` or `err` |
| req_tgt | input | 1 | 0 = primary selector, 1 = secondary selector |
| req_code | input | 2 | Target select code |
| busy | output | 1 | High whenever the controller is not idle |
| done | output | 1 | One-cycle pulse when a switch completes |
| err | output | 1 | One-cycle pulse when a request is rejected |
| ctrl | output | CTRL_W | Clock control register |
| pri_sel | output | 2 | Readback of the primary select |
| sec_sel | output | 2 | Readback of the secondary select |

## Verification
The hardest case to reach from the ports is a request whose pins change in the middle of a switch. The request is accepted, and then `req_tgt` and `req_code` jump to a legal secondary code partway through the settle wait. The bench reaches it with a driver task that keeps `req_valid` high and replaces the target and code a few cycles after acceptance. The scoreboard then confirms that only the captured primary change lands, with the normal busy length. A monitor also watches every cycle in which the secondary field moves and checks the gating bit around that change.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int SEL_W     = 2;
    localparam int PRI_LSB   = 0;
    localparam int SEC_LSB   = 2;
    localparam int GATE_BIT  = 4;
    localparam int DIV_LSB   = 6;
    localparam logic [SEL_W-1:0] PRI_BAD_CODE = 2'd3;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_IDLE,
        ST_PRI_WR,
        ST_PRI_SETTLE,
        ST_SEC_GATE_OFF,
        ST_SEC_WR,
        ST_SEC_SETTLE,
        ST_SEC_GATE_ON,
        ST_DONE,
        ST_REJECT
    } state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CLR_DIV,
        OP_WR_PRI,
        OP_GATE_SET,
        OP_WR_SEC,
        OP_GATE_CLR
    } reg_op_t;

endpackage

// File: rtl/clksel_timer.sv
module clksel_timer #(
    parameter int SETTLE_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    generate
        if (SETTLE_CYC <= 1) begin : g_single
            assign expired = en;
        end else begin : g_count
            localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!en) begin
                    cnt <= '0;
                end else if (cnt != LAST) begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign expired = en && (cnt == LAST);

            AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
                cnt <= LAST); // R6
        end
    endgenerate

endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm
    import clksel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_tgt,
    input  logic [SEL_W-1:0] req_code,
    input  logic             settle_exp,
    output logic             settle_en,
    output reg_op_t          op,
    output logic [SEL_W-1:0] op_code,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             init_active
);
    state_t state, state_nx;
    logic [SEL_W-1:0] code_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_INIT;
            code_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                code_q <= req_code;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT:         state_nx = ST_IDLE;
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_tgt)                      state_nx = ST_SEC_GATE_OFF;
                    else if (req_code == PRI_BAD_CODE) state_nx = ST_REJECT;
                    else                              state_nx = ST_PRI_WR;
                end
            end
            ST_PRI_WR:       state_nx = ST_PRI_SETTLE;
            ST_PRI_SETTLE:   if (settle_exp) state_nx = ST_DONE;
            ST_SEC_GATE_OFF: state_nx = ST_SEC_WR;
            ST_SEC_WR:       state_nx = ST_SEC_SETTLE;
            ST_SEC_SETTLE:   if (settle_exp) state_nx = ST_SEC_GATE_ON;
            ST_SEC_GATE_ON:  state_nx = ST_DONE;
            ST_DONE:         state_nx = ST_IDLE;
            ST_REJECT:       state_nx = ST_IDLE;
            default:         state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        op          = OP_NONE;
        settle_en   = 1'b0;
        done        = 1'b0;
        err         = 1'b0;
        init_active = 1'b0;
        busy        = (state != ST_IDLE);
        op_code     = code_q;
        unique case (state)
            ST_INIT: begin
                op          = OP_CLR_DIV;
                init_active = 1'b1;
            end
            ST_IDLE:         ;
            ST_PRI_WR:       op = OP_WR_PRI;
            ST_PRI_SETTLE:   settle_en = 1'b1;
            ST_SEC_GATE_OFF: op = OP_GATE_SET;
            ST_SEC_WR:       op = OP_WR_SEC;
            ST_SEC_SETTLE:   settle_en = 1'b1;
            ST_SEC_GATE_ON:  op = OP_GATE_CLR;
            ST_DONE:         done = 1'b1;
            ST_REJECT:       err = 1'b1;
            default:         ;
        endcase
    end

    AST_BUSY_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !err && !init_active) |=> busy); // R7
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !init_active && $past(busy)) |-> $stable(code_q)); // R7

endmodule

// File: rtl/clksel_regfile.sv
module clksel_regfile
    import clksel_pkg::*;
#(
    parameter int               CTRL_W    = 8,
    parameter logic [CTRL_W-1:0] CTRL_INIT = 8'hE5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_op_t           op,
    input  logic [SEL_W-1:0]  op_code,
    output logic [CTRL_W-1:0] ctrl
);
    function automatic logic [CTRL_W-1:0] put_field(
        input logic [CTRL_W-1:0] v, input int lsb, input logic [SEL_W-1:0] f);
        logic [CTRL_W-1:0] r;
        r = v;
        r[lsb +: SEL_W] = f;
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= CTRL_INIT;
        end else begin
            unique case (op)
                OP_NONE:     ;
                OP_CLR_DIV:  ctrl <= put_field(ctrl, DIV_LSB, '0);
                OP_WR_PRI:   ctrl <= put_field(ctrl, PRI_LSB, op_code);
                OP_GATE_SET: ctrl[GATE_BIT] <= 1'b1;
                OP_WR_SEC:   ctrl <= put_field(ctrl, SEC_LSB, op_code);
                OP_GATE_CLR: ctrl[GATE_BIT] <= 1'b0;
                default:     ;
            endcase
        end
    end

    AST_PRI_WR_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_PRI) |=> (ctrl[CTRL_W-1:SEL_W] == $past(ctrl[CTRL_W-1:SEL_W]))); // R2
    AST_PRI_NEVER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_PRI) |=> (ctrl[PRI_LSB +: SEL_W] != PRI_BAD_CODE)); // R3

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int               CTRL_W    = 8,
    parameter logic [CTRL_W-1:0] CTRL_INIT = 8'hE5,
    parameter int               REF_MHZ   = 200,
    parameter int               SETTLE_NS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_tgt,
    input  logic [1:0]        req_code,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CTRL_W-1:0] ctrl,
    output logic [1:0]        pri_sel,
    output logic [1:0]        sec_sel
);
    localparam int RAW_CYC    = (REF_MHZ * SETTLE_NS) / 1000;
    localparam int SETTLE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

    reg_op_t          op;
    logic [SEL_W-1:0] op_code;
    logic             settle_en;
    logic             settle_exp;
    logic             init_active;

    clksel_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_tgt     (req_tgt),
        .req_code    (req_code),
        .settle_exp  (settle_exp),
        .settle_en   (settle_en),
        .op          (op),
        .op_code     (op_code),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .init_active (init_active)
    );

    clksel_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (settle_en),
        .expired (settle_exp)
    );

    clksel_regfile #(.CTRL_W(CTRL_W), .CTRL_INIT(CTRL_INIT)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    assign pri_sel = ctrl[PRI_LSB +: SEL_W];
    assign sec_sel = ctrl[SEC_LSB +: SEL_W];

    AST_DIV_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !init_active |-> (ctrl[DIV_LSB +: 2] == 2'b00)); // R1
    AST_REJECT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> $stable(ctrl)); // R3
    AST_GATE_AROUND_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_sel != $past(sec_sel)) |-> (ctrl[GATE_BIT] && $past(ctrl[GATE_BIT]))); // R5
    AST_GATE_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ctrl[GATE_BIT]); // R5
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err})); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> busy); // R9

endmodule

// File: tb/clksel_ctrl_tb_top.sv
module clksel_ctrl_tb_top;

    localparam int S = (200 * 1000) / 1000;

    typedef struct packed {
        logic       is_err;
        logic       is_sec;
        logic [7:0] ctrl;
        int         blen;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_tgt = 1'b0;
    logic [1:0] req_code = 2'd0;
    logic       busy, done, err;
    logic [7:0] ctrl;
    logic [1:0] pri_sel, sec_sel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    item_t sb_q[$];
    logic [7:0] exp_ctrl;

    always #2.5 clk = ~clk;

    clksel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tgt(req_tgt),
        .req_code(req_code), .busy(busy), .done(done), .err(err),
        .ctrl(ctrl), .pri_sel(pri_sel), .sec_sel(sec_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // driver: push the expected result, hold the request until a pulse
    task automatic do_req(input logic tgt, input logic [1:0] code, input bit noise);
        item_t it;
        it.is_sec = tgt;
        it.is_err = (!tgt && code == 2'd3);
        if (!it.is_err) begin
            if (tgt) exp_ctrl[3:2] = code;
            else     exp_ctrl[1:0] = code;
        end
        it.ctrl = exp_ctrl;
        it.blen = it.is_err ? 1 : (tgt ? S + 4 : S + 2);
        sb_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b1; req_tgt = tgt; req_code = code;
        for (int n = 0; ; n++) begin
            @(negedge clk);
            if (noise && n == 3) begin
                req_tgt = ~tgt; req_code = code ^ 2'd1; // R7 pins change mid-switch
            end
            if (done || err) break;
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // monitor
    int   blen_cnt = 0;
    bit   gate_seen = 1'b0;
    int   neg_idx = 0;
    int   pri_chg_idx = -1;
    logic [1:0] prev_sec = 2'd0, prev_pri = 2'd0;
    logic prev_gate = 1'b0;
    initial begin
        @(posedge rst_n);
        @(negedge clk);
        prev_sec = sec_sel; prev_pri = pri_sel; prev_gate = ctrl[4];
        forever begin
            @(negedge clk);
            neg_idx++;
            if (busy) blen_cnt++; else blen_cnt = 0;
            if (ctrl[4]) gate_seen = 1'b1;
            chk(pri_sel == ctrl[1:0] && sec_sel == ctrl[3:2], "R8 readback",
                {pri_sel, sec_sel}, {ctrl[1:0], ctrl[3:2]});
            if (sec_sel != prev_sec)
                chk(ctrl[4] && prev_gate, "R5 gate around sec change", {prev_gate, ctrl[4]}, 2'b11);
            if (pri_sel != prev_pri) pri_chg_idx = neg_idx;
            if (busy && !prev_gate && !done && !err && req_valid) ; // request held
            if (done || err) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected pulse", {done, err}, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(err == it.is_err, it.is_err ? "R3 err pulse" : "R2/R4 done pulse", err, it.is_err);
                    chk(ctrl == it.ctrl, it.is_err ? "R3 ctrl unchanged" :
                        (it.is_sec ? "R4 ctrl" : "R2 ctrl"), ctrl, it.ctrl);
                    chk(blen_cnt == it.blen, it.is_err ? "R3 busy length" :
                        (it.is_sec ? "R4 busy length" : "R2 busy length"), blen_cnt, it.blen);
                    chk(!(done && err) && busy, "R9 pulse exclusive with busy", {done, err, busy}, 3'b101);
                    if (it.is_sec) chk(gate_seen && !ctrl[4], "R5 gate set then cleared",
                                        {gate_seen, ctrl[4]}, 2'b10);
                    if (!it.is_sec && !it.is_err)
                        chk(neg_idx - pri_chg_idx == S, "R6 settle length", neg_idx - pri_chg_idx, S);
                end
                gate_seen = 1'b0;
            end
            prev_sec = sec_sel; prev_pri = pri_sel; prev_gate = ctrl[4];
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // one-cycle pulse check R9
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done && done) chk(1'b0, "R9 done longer than one cycle", 1, 0);
            prev_done = done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ctrl == 8'hE5, "R1 reset value", ctrl, 8'hE5);
        chk(!busy && !done && !err || busy, "R1 reset outputs", {done, err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ctrl == 8'h25, "R1 div cleared after init", ctrl, 8'h25);
        chk(!busy && !done && !err, "R1 idle after init", {busy, done, err}, 0);
        chk(pri_sel == 2'd1 && sec_sel == 2'd1, "R8 readback after reset", {pri_sel, sec_sel}, 4'b0101);
        exp_ctrl = 8'h25;

        do_req(1'b0, 2'd2, 1'b0);  // R2 PLL div2
        do_req(1'b0, 2'd0, 1'b0);  // R2 secondary output
        do_req(1'b0, 2'd3, 1'b0);  // R3 illegal
        do_req(1'b0, 2'd1, 1'b0);  // R2 PLL
        do_req(1'b1, 2'd0, 1'b0);  // R4 safe bus clock
        do_req(1'b1, 2'd3, 1'b0);  // R4
        do_req(1'b0, 2'd2, 1'b1);  // R7 noisy pins while busy
        do_req(1'b1, 2'd2, 1'b1);  // R7 noisy pins on secondary
        do_req(1'b0, 2'd3, 1'b0);  // R3 again after secondary

        repeat (10) @(negedge clk);
        chk(ctrl == exp_ctrl && !busy, "R7 no late change after noise", ctrl, exp_ctrl);
        chk(ctrl[7:6] == 2'b00, "R1 div stays clear", ctrl[7:6], 0);
        chk(sb_q.size() == 0, "R9 all pulses seen", sb_q.size(), 0);
        finish_run();
    end

endmodule